// File: doc/BRIEF.md
# Banked Data Memory Addressing Unit

This block sits between an instruction decoder and a 512-byte data store split into four banks of 128 bytes. The decoder presents a 7-bit register field, an optional write with its data, and a request strobe. The unit builds a 9-bit physical address and performs the access against three kinds of target:

- the general-purpose storage;
- a bank control register;
- a pointer register.

Read data comes straight back in the same cycle.

There are two addressing forms:

- **Direct.** The field is extended with two bank-select bits held in the control register.
- **Indirect.** The unit uses the 8-bit pointer extended with one indirect-bank bit.

Indirect access is triggered by a field value of zero, the alias location. The control register and the pointer sit at the same offset in every bank, so software can reach them without switching banks. A write to either one affects every later access.

General-purpose storage covers a parameterised offset range in each bank. A per-bank enable mask leaves whole banks without storage. Every other location reads as zero and ignores writes.

Top module: `bmem_addr_unit`

## Requirements
- R1: When `req_i` is high and `addr_i` is not 00h, `phys_addr_o` equals {control bits [6:5], `addr_i`}. Bank-select values 00, 01, 10 and 11 select banks 0, 1, 2 and 3.
- R2: When `addr_i` is 00h, `phys_addr_o` equals {control bit 7, pointer}. A read returns the byte at that address, and a write goes to that address.
- R3: The control register is at offset 03h of every bank. A write through any bank's copy updates the single register, and a read returns the value stored.
- R4: The pointer register is at offset 04h of every bank. A write through any bank's copy updates the single register, and a read returns the value stored.
- R5: General-purpose bytes sit at offsets 20h..7Fh of each bank enabled in `BANK_EN`. A write with `req_i` and `we_i` high commits on the rising clock edge. A read is combinational from the computed address.
- R6: Offsets 01h, 02h and 05h..1Fh of every bank, and every general-purpose offset of a bank whose `BANK_EN` bit is 0, read as 00h and ignore writes. The default `BANK_EN` is 0111, so bank 3 has no storage.
- R7: When the pointer-derived address itself has offset 00h, a read returns 00h and a write changes nothing, including the control and pointer registers.
- R8: After reset, the control register and the pointer both hold 00h.
- R9: While `req_i` is low, `rdata_o` is 00h and no state changes, whatever `we_i` is.
- R10: A write to the control register changes the bank used by the very next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 7 | Register field from the instruction |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| phys_addr_o | output | 9 | Physical address of the current access |

## Verification
The checker verifies the following on every cycle:

- The two address-formation rules.
- The zero reads from reserved offsets, from the alias location and from an idle port.
- That the control register takes exactly the written byte.
- That the pointer holds its value unless a write targets offset 04h.

Some behaviour can only be shown by the bench's scenarios, because it depends on history:

- Storage contents surviving bank switches.
- A single shared pointer and control register seen through different banks' copies.
- Writes into a disabled bank or through the alias leaving nothing behind.
- A control write steering the very next access.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  localparam int unsigned BANK_SEL_W = 2;
  localparam int unsigned IBANK_BIT  = 7;
  localparam int unsigned DBANK_LSB  = 5;

  localparam logic [6:0] OFF_ALIAS  = 7'h00;
  localparam logic [6:0] OFF_STATUS = 7'h03;
  localparam logic [6:0] OFF_PTR    = 7'h04;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ALIAS,
    RGN_STATUS,
    RGN_PTR,
    RGN_GPR
  } region_e;
endpackage

// File: rtl/bmem_addr_gen.sv
module bmem_addr_gen #(
  parameter int unsigned FIELD_W = 7,
  parameter int unsigned BSEL_W  = 2,
  localparam int unsigned PTR_W  = FIELD_W + 1,
  localparam int unsigned PHYS_W = FIELD_W + BSEL_W
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [BSEL_W-1:0]  dbank_i,
  input  logic               ibank_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [PHYS_W-1:0]  phys_o,
  output logic               via_ptr_o
);
  always_comb begin
    via_ptr_o = (field_i == '0);
    if (via_ptr_o) phys_o = {ibank_i, ptr_i};
    else           phys_o = {dbank_i, field_i};
  end
endmodule

// File: rtl/bmem_decode.sv
module bmem_decode
  import bmem_pkg::*;
#(
  parameter int unsigned FIELD_W   = 7,
  parameter int unsigned BSEL_W    = 2,
  parameter int unsigned GPR_LO    = 32,
  parameter int unsigned GPR_HI    = 127,
  parameter logic [(1<<BSEL_W)-1:0] BANK_EN = '1,
  localparam int unsigned PHYS_W   = FIELD_W + BSEL_W,
  localparam int unsigned DEPTH    = GPR_HI - GPR_LO + 1,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [PHYS_W-1:0] phys_i,
  output region_e           region_o,
  output logic [BSEL_W-1:0] bank_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [FIELD_W-1:0] off;
  logic [FIELD_W-1:0] rel;

  assign off    = phys_i[FIELD_W-1:0];
  assign bank_o = phys_i[PHYS_W-1:FIELD_W];
  assign rel    = off - FIELD_W'(GPR_LO);
  assign idx_o  = rel[IDX_W-1:0];

  always_comb begin
    if (off == OFF_ALIAS)        region_o = RGN_ALIAS;
    else if (off == OFF_STATUS)  region_o = RGN_STATUS;
    else if (off == OFF_PTR)     region_o = RGN_PTR;
    else if (off >= FIELD_W'(GPR_LO) && off <= FIELD_W'(GPR_HI) && BANK_EN[bank_o])
                                 region_o = RGN_GPR;
    else                         region_o = RGN_NONE;
  end
endmodule

// File: rtl/bmem_ctl_regs.sv
module bmem_ctl_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_status_i,
  input  logic              wr_ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      ptr_o    <= '0;
    end else begin
      if (wr_status_i) status_o <= wdata_i;
      if (wr_ptr_i)    ptr_o    <= wdata_i;
    end
  end
endmodule

// File: rtl/bmem_gpr_array.sv
module bmem_gpr_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BSEL_W = 2,
  parameter int unsigned DEPTH  = 96,
  parameter logic [(1<<BSEL_W)-1:0] BANK_EN = '1,
  localparam int unsigned NBANK = 1 << BSEL_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BSEL_W-1:0] bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (BANK_EN[b]) begin : g_mem
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk_i) begin
        if (we_i && bank_i == BSEL_W'(b)) mem[idx_i] <= wdata_i;
      end
      assign bank_rd[b] = mem[idx_i];
    end else begin : g_void
      assign bank_rd[b] = '0;
    end
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/bmem_addr_unit.sv
module bmem_addr_unit
  import bmem_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GPR_LO = 32,
  parameter int unsigned GPR_HI = 127,
  parameter logic [3:0]  BANK_EN = 4'b0111,
  localparam int unsigned FIELD_W = DATA_W - 1,
  localparam int unsigned PHYS_W  = FIELD_W + BANK_SEL_W,
  localparam int unsigned DEPTH   = GPR_HI - GPR_LO + 1,
  localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [PHYS_W-1:0]  phys_addr_o
);
  logic [DATA_W-1:0]     status_q;
  logic [DATA_W-1:0]     ptr_q;
  logic                  via_ptr;
  region_e               region;
  logic [BANK_SEL_W-1:0] bank;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     gpr_rd;
  logic                  wr;

  bmem_addr_gen #(.FIELD_W(FIELD_W), .BSEL_W(BANK_SEL_W)) u_gen (
    .field_i   (addr_i),
    .dbank_i   (status_q[DBANK_LSB +: BANK_SEL_W]),
    .ibank_i   (status_q[IBANK_BIT]),
    .ptr_i     (ptr_q),
    .phys_o    (phys_addr_o),
    .via_ptr_o (via_ptr)
  );

  bmem_decode #(
    .FIELD_W(FIELD_W), .BSEL_W(BANK_SEL_W),
    .GPR_LO(GPR_LO), .GPR_HI(GPR_HI), .BANK_EN(BANK_EN)
  ) u_dec (
    .phys_i   (phys_addr_o),
    .region_o (region),
    .bank_o   (bank),
    .idx_o    (idx)
  );

  assign wr = req_i && we_i;

  bmem_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_status_i (wr && region == RGN_STATUS),
    .wr_ptr_i    (wr && region == RGN_PTR),
    .wdata_i     (wdata_i),
    .status_o    (status_q),
    .ptr_o       (ptr_q)
  );

  bmem_gpr_array #(
    .DATA_W(DATA_W), .BSEL_W(BANK_SEL_W), .DEPTH(DEPTH), .BANK_EN(BANK_EN)
  ) u_gpr (
    .clk_i   (clk_i),
    .we_i    (wr && region == RGN_GPR),
    .bank_i  (bank),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (gpr_rd)
  );

  // alias reached through the pointer falls into RGN_ALIAS and reads zero
  always_comb begin
    rdata_o = '0;
    if (req_i) begin
      unique case (region)
        RGN_STATUS: rdata_o = status_q;
        RGN_PTR:    rdata_o = ptr_q;
        RGN_GPR:    rdata_o = gpr_rd;
        default:    rdata_o = '0;
      endcase
    end
  end

  logic unused_via_ptr;
  assign unused_via_ptr = via_ptr;
endmodule

// File: rtl/bmem_addr_unit_chk.sv
module bmem_addr_unit_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GPR_LO = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [DATA_W-2:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W:0]   phys_addr_o,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] ptr_q
);
  logic [DATA_W-2:0] off;
  assign off = phys_addr_o[DATA_W-2:0];

  AST_DIRECT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i != '0) |-> phys_addr_o == {status_q[6:5], addr_i}); // R1

  AST_INDIRECT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == '0) |-> phys_addr_o == {status_q[7], ptr_q}); // R2

  AST_STATUS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && off == 7'h03) |=> status_q == $past(wdata_i)); // R3

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && off == 7'h04) |=> $stable(ptr_q)); // R4

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && off != 7'h00 && off != 7'h03 && off != 7'h04 && off < 7'(GPR_LO))
      |-> rdata_o == '0); // R6

  AST_ALIAS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == '0 && off == '0) |-> rdata_o == '0); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(status_q) && $stable(ptr_q)); // R9
endmodule

bind bmem_addr_unit bmem_addr_unit_chk #(.DATA_W(DATA_W), .GPR_LO(GPR_LO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .phys_addr_o (phys_addr_o),
  .status_q    (status_q),
  .ptr_q       (ptr_q)
);

// File: tb/bmem_addr_unit_bench.sv
`timescale 1ns/1ps
module bmem_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [8:0] phys;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic [8:0] a;
    bit         ca;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bmem_addr_unit u_bmem_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .phys_addr_o(phys)
  );

  task automatic acc(input bit r, input logic [6:0] f, input bit w, input logic [7:0] wd,
                     input bit chk, input logic [7:0] ed, input bit ca,
                     input logic [8:0] ea, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; addr = f; we = w; wdata = wd;
    if (chk) begin
      e.d = ed; e.a = ea; e.ca = ca; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic wr(input logic [6:0] f, input logic [7:0] d);
    acc(1'b1, f, 1'b1, d, 1'b0, 8'h00, 1'b0, 9'h000, "");
  endtask

  task automatic rd(input logic [6:0] f, input logic [7:0] ed, input string tag);
    acc(1'b1, f, 1'b0, 8'h00, 1'b1, ed, 1'b0, 9'h000, tag);
  endtask

  task automatic rda(input logic [6:0] f, input logic [7:0] ed, input logic [8:0] ea,
                     input string tag);
    acc(1'b1, f, 1'b0, 8'h00, 1'b1, ed, 1'b1, ea, tag);
  endtask

  // monitor: compares 1 ns after the driver's negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rdata !== e.d || (e.ca && phys !== e.a)) begin
          errors++;
          $display("FAIL %s: data %h addr %h, expected data %h addr %h",
                   e.tag, rdata, phys, e.d, e.ca ? e.a : phys);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rda(7'h03, 8'h00, 9'h003, "R8 control after reset");
    rda(7'h04, 8'h00, 9'h004, "R8 pointer after reset");

    wr(7'h20, 8'h11);
    rda(7'h20, 8'h11, 9'h020, "R5 bank0 low gpr");
    wr(7'h7F, 8'hAB);
    rda(7'h7F, 8'hAB, 9'h07F, "R5 bank0 top gpr");

    wr(7'h03, 8'h20);
    rda(7'h03, 8'h20, 9'h083, "R10 bank1 on next access");
    wr(7'h20, 8'h22);
    rda(7'h20, 8'h22, 9'h0A0, "R1 bank1 direct");

    wr(7'h03, 8'h40);
    rda(7'h03, 8'h40, 9'h103, "R3 written via bank1 copy");
    wr(7'h30, 8'h33);

    wr(7'h03, 8'h60);
    wr(7'h30, 8'h44);
    rda(7'h30, 8'h00, 9'h1B0, "R6 disabled bank3");
    wr(7'h04, 8'hA0);

    wr(7'h03, 8'h00);
    rda(7'h04, 8'hA0, 9'h004, "R4 pointer shared across banks");
    rda(7'h20, 8'h11, 9'h020, "R1 bank0 kept across switches");
    rda(7'h00, 8'h22, 9'h0A0, "R2 indirect low half");

    wr(7'h03, 8'h80);
    wr(7'h04, 8'h30);
    rda(7'h00, 8'h33, 9'h130, "R2 indirect high half");
    wr(7'h00, 8'h55);
    rd(7'h03, 8'h80, "R2 indirect write spared control");
    wr(7'h03, 8'hC0);
    rda(7'h30, 8'h55, 9'h130, "R2 indirect write landed");

    wr(7'h04, 8'h80);
    wr(7'h03, 8'h80);
    rda(7'h00, 8'h00, 9'h180, "R7 alias via pointer reads zero");
    wr(7'h00, 8'h77);
    rd(7'h03, 8'h80, "R7 alias write kept control");
    rd(7'h04, 8'h80, "R7 alias write kept pointer");

    wr(7'h04, 8'h00);
    wr(7'h03, 8'h00);
    wr(7'h00, 8'h66);
    rda(7'h00, 8'h00, 9'h000, "R7 bank0 alias self");
    rd(7'h03, 8'h00, "R7 bank0 alias write kept control");

    wr(7'h05, 8'h99);
    rda(7'h05, 8'h00, 9'h005, "R6 reserved 05h");
    rd(7'h1F, 8'h00, "R6 reserved 1Fh");
    rd(7'h01, 8'h00, "R6 reserved 01h");

    acc(1'b0, 7'h20, 1'b1, 8'hFF, 1'b1, 8'h00, 1'b0, 9'h000, "R9 idle reads zero");
    rd(7'h20, 8'h11, "R9 idle write ignored");

    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule